// File: doc/BRIEF.md
# Serial Link Loopback and Line-Fault Controller

This block is the digital routing and status core of a 16-bit serial link. Parallel transmit words are written into a small word FIFO. At each word boundary the serializer takes one word from the FIFO and shifts it out most-significant bit first. When the FIFO is empty it sends an all-zero word. The serial receive input is deserialized into 16-bit words, with the earliest bit landing in bit 15. Each completed word is marked by a one-cycle valid strobe. A single free-running word-phase counter, started by the release of core reset, sets the word boundaries for both directions.

Three loopback controls pick one of four data routes. The selection is a priority mode with four states: LB_BYPASS (the receive pin drives the transmit pin directly), LB_FACILITY (the receive pin, registered once, drives the transmit pin), LB_DIAG (the serializer output replaces the receive pin at the deserializer) and LB_NORMAL. The mode is chosen every cycle from the control inputs, and it moves straight to whichever mode is requested. A fourth control, loop timing, is passed to a clock-select output for the external clock mux.

A line-fault monitor in the reference-clock domain drives an active-low healthy flag. Its state machine has three states: LF_DOWN, LF_ARM and LF_UP. LF_DOWN goes to LF_ARM on a reference edge where the line is good. LF_ARM goes to LF_UP on a second consecutive good edge, and back to LF_DOWN otherwise. LF_UP stays in LF_UP while the line is good. Any loss of the line clears the state to LF_DOWN asynchronously, from any state. The line is good when reference lock is high and signal-detect is high, and signal-detect counts as high while LB_DIAG is the selected mode. The core reset and the FIFO reset are separate.

Top module: `serdes_lb_ctrl`

## Requirements
- R1: The serial output in LB_NORMAL and LB_DIAG sends each loaded word bit 15 first, one bit per clock. A word is taken from the FIFO at the clock edge where the word-phase count is 15, and an all-zero word is sent when the FIFO is empty.
- R2: The deserializer shifts in one bit per clock. At the edge where the word-phase count is 15 it outputs the last 16 bits received, with the earliest in bit 15, and raises rx_valid for exactly one cycle. This happens at edges 15, 31, 47 and so on, counted from the release of core reset.
- R3: Mode priority is lb_bypass over lb_facility over lb_diag over normal operation.
- R4: In LB_FACILITY the serial output equals the serial input sampled at the previous clock edge, and the deserializer still receives the serial input.
- R5: In LB_DIAG the deserializer receives the serializer output instead of the serial input. A word written to the FIFO therefore reappears on rx_data 16 clocks after it is loaded.
- R6: In LB_BYPASS the serial output follows the serial input with no register stage.
- R7: tx_clk_sel always equals loop_time (1 = recovered receive clock, 0 = transmit PLL clock).
- R8: lfi_n goes low at once, without waiting for a clock edge, whenever ref_lock is low or sig_det is low. A low sig_det is ignored while LB_DIAG is the selected mode.
- R9: lfi_n goes high only after the line has been good on two consecutive ref_clk rising edges.
- R10: rst_n low clears the word-phase counter, the shifters, the retiming register and the fault monitor (lfi_n = 0), but not the FIFO contents. fifo_rst_n low empties the FIFO only.
- R11: tx_full is high when the FIFO holds DEPTH (4) words, and a write while full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock for the shifters and FIFO |
| ref_clk | input | 1 | Reference clock for the fault monitor |
| rst_n | input | 1 | Active-low core reset (everything except the FIFO) |
| fifo_rst_n | input | 1 | Active-low FIFO reset |
| tx_wr_en | input | 1 | Write strobe for tx_data |
| tx_data | input | 16 | Parallel transmit word |
| tx_full | output | 1 | FIFO holds DEPTH words |
| ser_in | input | 1 | Serial receive bit |
| ser_out | output | 1 | Serial transmit bit |
| rx_data | output | 16 | Last deserialized word |
| rx_valid | output | 1 | One-cycle strobe for a new rx_data |
| lb_facility | input | 1 | Request retimed line loopback |
| lb_diag | input | 1 | Request diagnostic loopback |
| lb_bypass | input | 1 | Request non-retimed line loopback |
| loop_time | input | 1 | Request loop-timed transmit clock |
| tx_clk_sel | output | 1 | Transmit shifter clock select |
| sig_det | input | 1 | Signal detect from the line |
| ref_lock | input | 1 | Reference lock indication |
| lfi_n | output | 1 | Line healthy flag, low on fault |

## Verification
Some properties are checked on every cycle. These are the unregistered path in LB_BYPASS, the one-clock delay in LB_FACILITY, the single-cycle rx_valid strobe with its fixed phase from reset, the clock-select pass-through, and the rule that lfi_n is low whenever the line is not good. Other behaviour only the bench scenarios can show, by comparing against a bit-level reference model. This covers word ordering through the FIFO, the round trip of a transmit word in LB_DIAG, the priority when several controls are high, dropped writes to a full FIFO, the FIFO surviving a core reset, and the two-edge recovery of lfi_n.

// File: rtl/serdes_lb_pkg.sv
package serdes_lb_pkg;

    typedef enum logic [1:0] {
        LB_NORMAL   = 2'd0,
        LB_DIAG     = 2'd1,
        LB_FACILITY = 2'd2,
        LB_BYPASS   = 2'd3
    } lb_mode_e;

    typedef enum logic [1:0] {
        LF_DOWN = 2'd0,
        LF_ARM  = 2'd1,
        LF_UP   = 2'd2
    } lf_state_e;

endpackage

// File: rtl/sl_tx_fifo.sv
module sl_tx_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] count;
    logic          do_wr, do_rd;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign rd_data = mem[rp];

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wp] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_wr) wp <= wrap_inc(wp);
            if (do_rd) rp <= wrap_inc(rp);
            count <= count + CW'(do_wr) - CW'(do_rd);
        end
    end
endmodule

// File: rtl/sl_shifters.sv
module sl_tx_shifter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_word,
    output logic         bit_out
);
    logic [W-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh <= '0;
        end else if (load) begin
            sh <= load_word;
        end else begin
            sh <= {sh[W-2:0], 1'b0};
        end
    end

    assign bit_out = sh[W-1];
endmodule

module sl_rx_shifter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_in,
    input  logic         word_end,
    output logic [W-1:0] word_out,
    output logic         word_valid
);
    logic [W-1:0] des;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            des        <= '0;
            word_out   <= '0;
            word_valid <= 1'b0;
        end else begin
            des        <= {des[W-2:0], bit_in};
            word_valid <= word_end;
            if (word_end) begin
                word_out <= {des[W-2:0], bit_in};
            end
        end
    end
endmodule

// File: rtl/sl_fault_mon.sv
module sl_fault_mon
    import serdes_lb_pkg::*;
(
    input  logic ref_clk,
    input  logic rst_n,
    input  logic sig_det,
    input  logic ref_lock,
    input  logic mask_sd,
    output logic lfi_n
);
    lf_state_e state, state_nx;
    logic      line_good;
    logic      clr_n;

    assign line_good = ref_lock && (sig_det || mask_sd);
    // loss of line clears the state without waiting for ref_clk
    assign clr_n     = rst_n && line_good;

    always_comb begin
        state_nx = state;
        unique case (state)
            LF_DOWN: state_nx = line_good ? LF_ARM : LF_DOWN;
            LF_ARM:  state_nx = line_good ? LF_UP  : LF_DOWN;
            LF_UP:   state_nx = line_good ? LF_UP  : LF_DOWN;
            default: state_nx = LF_DOWN;
        endcase
    end

    always_ff @(posedge ref_clk or negedge clr_n) begin
        if (!clr_n) begin
            state <= LF_DOWN;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        unique case (state)
            LF_UP:   lfi_n = 1'b1;
            LF_ARM:  lfi_n = 1'b0;
            LF_DOWN: lfi_n = 1'b0;
            default: lfi_n = 1'b0;
        endcase
    end
endmodule

// File: rtl/serdes_lb_ctrl.sv
module serdes_lb_ctrl
    import serdes_lb_pkg::*;
#(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         ref_clk,
    input  logic         rst_n,
    input  logic         fifo_rst_n,
    input  logic         tx_wr_en,
    input  logic [W-1:0] tx_data,
    output logic         tx_full,
    input  logic         ser_in,
    output logic         ser_out,
    output logic [W-1:0] rx_data,
    output logic         rx_valid,
    input  logic         lb_facility,
    input  logic         lb_diag,
    input  logic         lb_bypass,
    input  logic         loop_time,
    output logic         tx_clk_sel,
    input  logic         sig_det,
    input  logic         ref_lock,
    output logic         lfi_n
);
    localparam int PW = $clog2(W);

    lb_mode_e     mode;
    logic [PW-1:0] phase;
    logic         word_end;
    logic [W-1:0] fifo_word;
    logic         fifo_empty;
    logic         tx_bit;
    logic         rx_src;
    logic         ser_in_q;

    // mode priority: bypass, facility, diagnostic, normal
    always_comb begin
        if (lb_bypass)        mode = LB_BYPASS;
        else if (lb_facility) mode = LB_FACILITY;
        else if (lb_diag)     mode = LB_DIAG;
        else                  mode = LB_NORMAL;
    end

    assign word_end = (phase == PW'(W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase    <= '0;
            ser_in_q <= 1'b0;
        end else begin
            phase    <= word_end ? '0 : phase + 1'b1;
            ser_in_q <= ser_in;
        end
    end

    sl_tx_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (fifo_rst_n),
        .wr_en   (tx_wr_en),
        .wr_data (tx_data),
        .rd_en   (word_end),
        .rd_data (fifo_word),
        .empty   (fifo_empty),
        .full    (tx_full)
    );

    sl_tx_shifter #(.W(W)) u_txsh (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (word_end),
        .load_word (fifo_empty ? '0 : fifo_word),
        .bit_out   (tx_bit)
    );

    always_comb begin
        unique case (mode)
            LB_DIAG:     rx_src = tx_bit;
            LB_NORMAL,
            LB_FACILITY,
            LB_BYPASS:   rx_src = ser_in;
            default:     rx_src = ser_in;
        endcase
    end

    sl_rx_shifter #(.W(W)) u_rxsh (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_in     (rx_src),
        .word_end   (word_end),
        .word_out   (rx_data),
        .word_valid (rx_valid)
    );

    always_comb begin
        unique case (mode)
            LB_BYPASS:   ser_out = ser_in;
            LB_FACILITY: ser_out = ser_in_q;
            LB_DIAG,
            LB_NORMAL:   ser_out = tx_bit;
            default:     ser_out = tx_bit;
        endcase
    end

    assign tx_clk_sel = loop_time;

    sl_fault_mon u_fault (
        .ref_clk  (ref_clk),
        .rst_n    (rst_n),
        .sig_det  (sig_det),
        .ref_lock (ref_lock),
        .mask_sd  (mode == LB_DIAG),
        .lfi_n    (lfi_n)
    );
endmodule

// File: rtl/serdes_lb_ctrl_chk.sv
module serdes_lb_ctrl_chk #(
    parameter int W = 16
) (
    input logic clk,
    input logic ref_clk,
    input logic rst_n,
    input logic ser_in,
    input logic ser_out,
    input logic rx_valid,
    input logic lb_facility,
    input logic lb_diag,
    input logic lb_bypass,
    input logic loop_time,
    input logic tx_clk_sel,
    input logic sig_det,
    input logic ref_lock,
    input logic lfi_n
);
    localparam int PW = $clog2(W);

    logic          armed;
    logic [PW-1:0] pc;
    logic          diag_sel;

    assign diag_sel = lb_diag && !lb_facility && !lb_bypass;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed <= 1'b0;
            pc    <= '0;
        end else begin
            armed <= 1'b1;
            pc    <= pc + 1'b1;
        end
    end

    assert_bypass_direct_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lb_bypass |-> (ser_out == ser_in));

    assert_facility_retime_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && lb_facility && !lb_bypass) |-> (ser_out == $past(ser_in)));

    assert_valid_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_valid_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid == (armed && pc == '0));

    assert_clk_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_clk_sel == loop_time);

    assert_fault_low_R8: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !(ref_lock && (sig_det || diag_sel)) |-> !lfi_n);
endmodule

bind serdes_lb_ctrl serdes_lb_ctrl_chk #(.W(W)) u_chk (
    .clk         (clk),
    .ref_clk     (ref_clk),
    .rst_n       (rst_n),
    .ser_in      (ser_in),
    .ser_out     (ser_out),
    .rx_valid    (rx_valid),
    .lb_facility (lb_facility),
    .lb_diag     (lb_diag),
    .lb_bypass   (lb_bypass),
    .loop_time   (loop_time),
    .tx_clk_sel  (tx_clk_sel),
    .sig_det     (sig_det),
    .ref_lock    (ref_lock),
    .lfi_n       (lfi_n)
);

// File: tb/serdes_lb_ctrl_tb.sv
module serdes_lb_ctrl_tb;
    localparam int W = 16;
    localparam int DEPTH = 4;

    logic clk = 1'b0, ref_clk = 1'b0;
    logic rst_n = 1'b0, fifo_rst_n = 1'b0;
    logic tx_wr_en = 1'b0;
    logic [W-1:0] tx_data = '0;
    logic tx_full, ser_out, rx_valid, tx_clk_sel, lfi_n;
    logic [W-1:0] rx_data;
    logic ser_in = 1'b0;
    logic lb_facility = 1'b0, lb_diag = 1'b0, lb_bypass = 1'b0, loop_time = 1'b0;
    logic sig_det = 1'b0, ref_lock = 1'b0;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    serdes_lb_ctrl #(.W(W), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .ref_clk(ref_clk), .rst_n(rst_n), .fifo_rst_n(fifo_rst_n),
        .tx_wr_en(tx_wr_en), .tx_data(tx_data), .tx_full(tx_full),
        .ser_in(ser_in), .ser_out(ser_out), .rx_data(rx_data), .rx_valid(rx_valid),
        .lb_facility(lb_facility), .lb_diag(lb_diag), .lb_bypass(lb_bypass),
        .loop_time(loop_time), .tx_clk_sel(tx_clk_sel),
        .sig_det(sig_det), .ref_lock(ref_lock), .lfi_n(lfi_n)
    );

    always #5 clk = ~clk;
    initial begin
        #3;
        forever #20 ref_clk = ~ref_clk;
    end

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [W-1:0] fq[$];
    int           m_cnt = 0, m_idx = 0, m_f = 0;
    logic [W-1:0] m_word = '0, m_bits = '0, m_rx = '0;
    logic         m_val = 1'b0, m_ret = 1'b0;

    function automatic bit diag_on();
        return lb_diag && !lb_facility && !lb_bypass;
    endfunction
    function automatic bit good_now();
        return ref_lock && (sig_det || diag_on());
    endfunction

    always @(posedge clk) begin
        bit wr_ok;
        wr_ok = tx_wr_en && fifo_rst_n && (fq.size() < DEPTH);
        if (!fifo_rst_n) fq.delete();
        if (!rst_n) begin
            m_cnt = 0; m_idx = 0; m_word = '0; m_bits = '0;
            m_rx = '0; m_val = 1'b0; m_ret = 1'b0;
        end else begin
            logic src;
            src = diag_on() ? m_word[W-1-m_idx] : ser_in;
            m_bits = {m_bits[W-2:0], src};
            m_val = (m_cnt == W-1);
            if (m_val) m_rx = m_bits;
            m_ret = ser_in;
            if (m_cnt == W-1) begin
                m_word = (fq.size() > 0) ? fq.pop_front() : '0;
                m_idx = 0;
            end else begin
                m_idx++;
            end
            m_cnt = (m_cnt + 1) % W;
        end
        if (wr_ok) fq.push_back(tx_data);
    end

    always @(negedge clk) begin
        logic exp_so;
        string so_tag, rx_tag;
        if (lb_bypass)        begin exp_so = ser_in; so_tag = "R6/R3 ser_out"; end
        else if (lb_facility) begin exp_so = m_ret;  so_tag = "R4 ser_out"; end
        else                  begin exp_so = m_word[W-1-m_idx]; so_tag = "R1 ser_out"; end
        rx_tag = diag_on() ? "R5 rx_data" : (lb_facility ? "R4 rx_data" : "R2 rx_data");
        chk(so_tag, W'(ser_out), W'(exp_so));
        chk(rx_tag, rx_data, m_rx);
        chk("R2 rx_valid", W'(rx_valid), W'(m_val));
        chk("R11 tx_full", W'(tx_full), W'(fq.size() == DEPTH));
        chk("R7 tx_clk_sel", W'(tx_clk_sel), W'(loop_time));
    end

    // fault model: asynchronous clear, two good ref edges to recover
    always @(rst_n or ref_lock or sig_det or lb_diag or lb_facility or lb_bypass) begin
        if (!(rst_n && good_now())) m_f = 0;
    end
    always @(posedge ref_clk) begin
        if (!(rst_n && good_now())) m_f = 0;
        else m_f = (m_f == 0) ? 1 : 2;
    end
    always @(negedge ref_clk) begin
        chk("R9/R8 lfi_n", W'(lfi_n), W'(m_f == 2));
    end

    // ---------------- stimulus ----------------
    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #2;
            ser_in = 1'($urandom);
        end
    endtask

    task automatic put(input logic [W-1:0] d);
        @(negedge clk);
        #2;
        tx_wr_en = 1'b1;
        tx_data  = d;
        ser_in   = 1'($urandom);
        @(negedge clk);
        #2;
        tx_wr_en = 1'b0;
    endtask

    initial begin
        step(3);
        // reset state (R10)
        chk("R10 reset lfi_n", W'(lfi_n), '0);
        chk("R10 reset rx_valid", W'(rx_valid), '0);
        chk("R10 reset tx_full", W'(tx_full), '0);
        rst_n = 1'b1; fifo_rst_n = 1'b1;
        sig_det = 1'b1; ref_lock = 1'b1;

        // R1/R11: fill FIFO, extra write dropped
        put(16'hA5C3); put(16'h8001); put(16'h7FFE); put(16'h1234);
        chk("R11 full after four", W'(tx_full), 16'h1);
        put(16'hDEAD);
        step(100);

        // R5 diagnostic loopback, sig_det masked (R8)
        lb_diag = 1'b1; sig_det = 1'b0;
        put(16'hC0DE); put(16'h0F0F); put(16'hFFFF);
        step(90);
        #4;
        chk("R8 sig_det masked in diag", W'(lfi_n), 16'h1);
        sig_det = 1'b1;

        // R4 facility, with diag still requested (R3)
        lb_facility = 1'b1; loop_time = 1'b1;
        step(40);
        // R6 bypass with all requests high (R3)
        lb_bypass = 1'b1;
        step(40);
        lb_bypass = 1'b0; lb_facility = 1'b0; lb_diag = 1'b0; loop_time = 1'b0;
        step(20);

        // R8 asynchronous fault, R9 two-edge recovery
        @(negedge clk); #2;
        ref_lock = 1'b0;
        #2;
        chk("R8 lfi_n drops at once", W'(lfi_n), '0);
        ref_lock = 1'b1;
        @(posedge ref_clk); #3;
        chk("R9 still low after one edge", W'(lfi_n), '0);
        @(posedge ref_clk); #3;
        chk("R9 high after two edges", W'(lfi_n), 16'h1);
        @(negedge clk); #2;
        sig_det = 1'b0;
        #2;
        chk("R8 sig_det drop", W'(lfi_n), '0);
        sig_det = 1'b1;
        step(20);

        // R10: core reset keeps FIFO, FIFO reset clears it
        put(16'h1111); put(16'h2222); put(16'h3333); put(16'h4444);
        @(negedge clk); #2;
        rst_n = 1'b0;
        step(20);
        chk("R10 FIFO kept over core reset", W'(tx_full), 16'h1);
        chk("R10 lfi_n low in core reset", W'(lfi_n), '0);
        rst_n = 1'b1;
        step(5);
        fifo_rst_n = 1'b0;
        step(2);
        chk("R10 FIFO reset empties", W'(tx_full), '0);
        fifo_rst_n = 1'b1;
        step(40);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule